// File: doc/BRIEF.md
# I2C Acknowledge-Slot Clock Stretch Controller

This block decides whether an I2C port, acting as master or slave, holds SCL low after the SCL falling edge that leads into an acknowledge slot. At that edge it compares the transfer direction with the FIFO state. A read, where this port sends data, needs a byte in the transmit FIFO. A write, where this port takes data in, needs room in the receive FIFO. If the needed resource is missing and stretching is enabled, SCL is held low. This gives software time to load or drain the FIFO. The bit shifter and the FIFO storage sit outside this block.

While SCL is held, an optional timeout counts system clocks against a programmable limit. The counter restarts at zero for each stretch. If the FIFO condition clears first, SCL is released on the next clock and the normal acknowledge goes ahead. If the limit is reached first, SCL is released and a fixed fallback is commanded:
- a NACK when the receive FIFO is full;
- a NACK when the transmit FIFO is empty after the R/W bit of the address byte;
- a resend of the previous byte when the transmit FIFO is empty on a later byte of the same read.

Every timeout sets a sticky flag. No data passes through this block, so every pin is a plain control or status signal and there is no valid/ready handshake.

Top module: `scl_stretch_ctrl`

## Requirements
- R1: After reset, `scl_hold_o`, `force_nack_o`, `resend_last_o` and `tmo_flag_o` are all 0.
- R2: A cycle with `ack_edge_i`=1, `rw_read_i`=1 (read) and `txf_empty_i`=1, while `stretch_en_i`=1, sets `scl_hold_o` to 1 from the following cycle. In this direction `rxf_full_i` has no effect.
- R3: A cycle with `ack_edge_i`=1, `rw_read_i`=0 (write) and `rxf_full_i`=1, while `stretch_en_i`=1, sets `scl_hold_o` to 1 from the following cycle. In this direction `txf_empty_i` has no effect.
- R4: An `ack_edge_i` strobe whose direction-relevant FIFO condition is absent produces no hold and no fallback pulse.
- R5: While holding, the first clock edge that samples the condition cleared drops `scl_hold_o`, and no fallback pulse follows.
- R6: With `tmo_en_i`=1, a stretch whose condition never clears lasts exactly max(`tmo_limit_i`,1) cycles. If the condition clears on the same edge that the limit is reached, the release counts as a normal release and not as a timeout.
- R7: A timeout of a write (receive-full) stretch gives a one-cycle `force_nack_o` pulse in the first cycle with `scl_hold_o`=0.
- R8: A timeout of a read stretch gives a one-cycle `force_nack_o` pulse if `addr_phase_i` was 1 at the strobe (the R/W bit of the address byte), and otherwise a one-cycle `resend_last_o` pulse. The pulse comes in the first cycle after the release.
- R9: Every timeout sets `tmo_flag_o`, and it stays set until `tmo_clr_i` is asserted for a cycle. Normal releases never set it.
- R10: With `tmo_en_i`=0, the hold lasts until the condition clears, however long that takes.
- R11: With `stretch_en_i`=0, a strobe that meets a FIFO condition never raises `scl_hold_o` and does not set the flag. The fallback of R7/R8 is pulsed in the cycle after the strobe.
- R12: An `ack_edge_i` strobe that arrives while the hold is active is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| stretch_en_i | input | 1 | Enables holding SCL |
| tmo_en_i | input | 1 | Enables the stretch timeout |
| tmo_limit_i | input | TMO_W | Timeout length in system clocks (0 behaves as 1) |
| tmo_clr_i | input | 1 | Clears the sticky timeout flag |
| ack_edge_i | input | 1 | One-cycle strobe: SCL fell ahead of an acknowledge slot |
| addr_phase_i | input | 1 | The byte at the strobe is the address byte (R/W bit) |
| rw_read_i | input | 1 | 1 = this port transmits (read), 0 = it receives |
| txf_empty_i | input | 1 | Transmit FIFO holds no byte |
| rxf_full_i | input | 1 | Receive FIFO has no free entry |
| scl_hold_o | output | 1 | Request to hold SCL low |
| force_nack_o | output | 1 | One-cycle command to answer NACK |
| resend_last_o | output | 1 | One-cycle command to resend the previous byte |
| tmo_flag_o | output | 1 | Sticky stretch-timeout flag |

## Verification
The hardest case to reach is a condition that clears on exactly the edge where the timeout limit is reached. Both the release and the timeout compete on that edge, and only the release may win. The bench sweeps small timeout limits against the clock on which it withdraws the FIFO condition, counted from the strobe, so every limit meets a clear that comes earlier, on the same edge, and later. For each stretch it also fires a second strobe on the first held edge, to show that a strobe during a hold is ignored even when that edge is also the release edge.

// File: rtl/scl_stretch_pkg.sv
package scl_stretch_pkg;

  typedef enum logic [1:0] {
    CAUSE_NONE = 2'd0,
    CAUSE_TX   = 2'd1,
    CAUSE_RX   = 2'd2
  } cause_e;

  typedef enum logic [1:0] {
    FB_NONE   = 2'd0,
    FB_NACK   = 2'd1,
    FB_RESEND = 2'd2
  } fallback_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_HOLD = 1'b1
  } state_e;

  // Response applied when a stretch cannot be satisfied
  function automatic fallback_e fallback_for(cause_e c, logic addr_byte);
    fallback_e f;
    case (c)
      CAUSE_RX: f = FB_NACK;
      CAUSE_TX: f = addr_byte ? FB_NACK : FB_RESEND;
      default:  f = FB_NONE;
    endcase
    return f;
  endfunction

endpackage

// File: rtl/stretch_cause.sv
module stretch_cause
  import scl_stretch_pkg::*;
(
  input  logic      rw_read_i,
  input  logic      addr_phase_i,
  input  logic      txf_empty_i,
  input  logic      rxf_full_i,
  output cause_e    cause_o,
  output fallback_e fallback_o
);

  always_comb begin
    cause_o = CAUSE_NONE;
    if (rw_read_i) begin
      if (txf_empty_i) cause_o = CAUSE_TX;
    end else begin
      if (rxf_full_i) cause_o = CAUSE_RX;
    end
    fallback_o = fallback_for(cause_o, addr_phase_i);
  end

endmodule

// File: rtl/stretch_timer.sv
module stretch_timer #(
  parameter int TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             run_i,
  input  logic             tmo_en_i,
  input  logic [TMO_W-1:0] limit_i,
  output logic             expire_o
);

  localparam int CW = TMO_W + 1;

  logic [TMO_W-1:0] cnt_q;
  logic [CW-1:0]    next_cnt;

  assign next_cnt = {1'b0, cnt_q} + CW'(1);
  assign expire_o = run_i && tmo_en_i && (next_cnt >= {1'b0, limit_i});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (start_i) begin
      cnt_q <= '0;
    end else if (run_i && !expire_o) begin
      cnt_q <= next_cnt[TMO_W-1:0];
    end
  end

  // R6: the counter is zero on the first held cycle
  assert_restart_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (cnt_q == '0));

  // R6: with a stable limit the counter never passes it while running
  assert_cnt_bounded_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && tmo_en_i && !start_i && $stable(limit_i) && (cnt_q < limit_i))
      |=> (cnt_q <= limit_i));

endmodule

// File: rtl/stretch_fsm.sv
module stretch_fsm
  import scl_stretch_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      stretch_en_i,
  input  logic      ack_edge_i,
  input  cause_e    cause_i,
  input  fallback_e fallback_i,
  input  logic      txf_empty_i,
  input  logic      rxf_full_i,
  input  logic      expire_i,
  input  logic      tmo_clr_i,
  output logic      timer_start_o,
  output logic      timer_run_o,
  output logic      scl_hold_o,
  output logic      force_nack_o,
  output logic      resend_last_o,
  output logic      tmo_flag_o
);

  state_e    state_q, state_d;
  cause_e    cause_q, cause_d;
  fallback_e fb_q, fb_d;
  fallback_e pulse_d;
  logic      tmo_hit;
  logic      cond_live;
  logic      nack_q, resend_q, flag_q;

  always_comb begin
    case (cause_q)
      CAUSE_TX: cond_live = txf_empty_i;
      CAUSE_RX: cond_live = rxf_full_i;
      default:  cond_live = 1'b0;
    endcase
  end

  always_comb begin
    state_d       = state_q;
    cause_d       = cause_q;
    fb_d          = fb_q;
    pulse_d       = FB_NONE;
    tmo_hit       = 1'b0;
    timer_start_o = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (ack_edge_i && (cause_i != CAUSE_NONE)) begin
          if (stretch_en_i) begin
            state_d       = ST_HOLD;
            cause_d       = cause_i;
            fb_d          = fallback_i;
            timer_start_o = 1'b1;
          end else begin
            pulse_d = fallback_i;
          end
        end
      end
      ST_HOLD: begin
        if (!cond_live) begin
          state_d = ST_IDLE;
          cause_d = CAUSE_NONE;
        end else if (expire_i) begin
          state_d = ST_IDLE;
          cause_d = CAUSE_NONE;
          pulse_d = fb_q;
          tmo_hit = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      cause_q  <= CAUSE_NONE;
      fb_q     <= FB_NONE;
      nack_q   <= 1'b0;
      resend_q <= 1'b0;
      flag_q   <= 1'b0;
    end else begin
      state_q  <= state_d;
      cause_q  <= cause_d;
      fb_q     <= fb_d;
      nack_q   <= (pulse_d == FB_NACK);
      resend_q <= (pulse_d == FB_RESEND);
      if (tmo_hit)        flag_q <= 1'b1;
      else if (tmo_clr_i) flag_q <= 1'b0;
    end
  end

  assign timer_run_o   = (state_q == ST_HOLD);
  assign scl_hold_o    = (state_q == ST_HOLD);
  assign force_nack_o  = nack_q;
  assign resend_last_o = resend_q;
  assign tmo_flag_o    = flag_q;

  // R7/R8: never both fallback commands at once
  assert_single_fallback_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({force_nack_o, resend_last_o}));

  // R2/R3: a hold only begins after an enabled strobe
  assert_hold_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_hold_o) |-> $past(ack_edge_i && stretch_en_i));

  // R9: the flag only rises at the end of a hold
  assert_flag_from_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tmo_flag_o) |-> ($past(scl_hold_o) && !scl_hold_o));

  // R7/R8: a fallback pulse is never issued while SCL is held
  assert_pulse_released_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (force_nack_o || resend_last_o) |-> !scl_hold_o);

  // R9: the flag is sticky until cleared
  assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo_flag_o && !tmo_clr_i) |=> tmo_flag_o);

endmodule

// File: rtl/scl_stretch_ctrl.sv
module scl_stretch_ctrl
  import scl_stretch_pkg::*;
#(
  parameter int TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stretch_en_i,
  input  logic             tmo_en_i,
  input  logic [TMO_W-1:0] tmo_limit_i,
  input  logic             tmo_clr_i,
  input  logic             ack_edge_i,
  input  logic             addr_phase_i,
  input  logic             rw_read_i,
  input  logic             txf_empty_i,
  input  logic             rxf_full_i,
  output logic             scl_hold_o,
  output logic             force_nack_o,
  output logic             resend_last_o,
  output logic             tmo_flag_o
);

  cause_e    cause;
  fallback_e fallback;
  logic      t_start, t_run, t_expire;

  stretch_cause u_cause (
    .rw_read_i    (rw_read_i),
    .addr_phase_i (addr_phase_i),
    .txf_empty_i  (txf_empty_i),
    .rxf_full_i   (rxf_full_i),
    .cause_o      (cause),
    .fallback_o   (fallback)
  );

  stretch_timer #(.TMO_W(TMO_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (t_start),
    .run_i    (t_run),
    .tmo_en_i (tmo_en_i),
    .limit_i  (tmo_limit_i),
    .expire_o (t_expire)
  );

  stretch_fsm u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .stretch_en_i  (stretch_en_i),
    .ack_edge_i    (ack_edge_i),
    .cause_i       (cause),
    .fallback_i    (fallback),
    .txf_empty_i   (txf_empty_i),
    .rxf_full_i    (rxf_full_i),
    .expire_i      (t_expire),
    .tmo_clr_i     (tmo_clr_i),
    .timer_start_o (t_start),
    .timer_run_o   (t_run),
    .scl_hold_o    (scl_hold_o),
    .force_nack_o  (force_nack_o),
    .resend_last_o (resend_last_o),
    .tmo_flag_o    (tmo_flag_o)
  );

  // R11: with stretching disabled a hold can never begin
  assert_no_hold_disabled_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!stretch_en_i && !scl_hold_o) |=> !scl_hold_o);

  // R5: a hold whose condition has cleared ends without a fallback
  assert_clean_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_hold_o && ((rw_read_i && !txf_empty_i) || (!rw_read_i && !rxf_full_i))
      && $stable(rw_read_i))
      |=> (!force_nack_o && !resend_last_o));

endmodule

// File: tb/scl_stretch_ctrl_tb_top.sv
module scl_stretch_ctrl_tb_top;

  localparam int TMO_W = 16;
  localparam int NSAMP = 12;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             stretch_en = 1'b0, tmo_en = 1'b0, tmo_clr = 1'b0;
  logic [TMO_W-1:0] tmo_limit = '0;
  logic             ack_edge = 1'b0, addr_phase = 1'b0, rw_read = 1'b0;
  logic             txf_empty = 1'b0, rxf_full = 1'b0;
  logic             scl_hold, force_nack, resend_last, tmo_flag;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  scl_stretch_ctrl #(.TMO_W(TMO_W)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .stretch_en_i(stretch_en), .tmo_en_i(tmo_en), .tmo_limit_i(tmo_limit),
    .tmo_clr_i(tmo_clr), .ack_edge_i(ack_edge), .addr_phase_i(addr_phase),
    .rw_read_i(rw_read), .txf_empty_i(txf_empty), .rxf_full_i(rxf_full),
    .scl_hold_o(scl_hold), .force_nack_o(force_nack),
    .resend_last_o(resend_last), .tmo_flag_o(tmo_flag)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // One acknowledge-slot episode; d = sampled edge at which the condition is seen cleared
  task automatic run_case(input int lim, input bit te, input bit se, input bit rd,
                          input bit addr, input bit trig, input int d);
    int  exp_r, lc, exp_pulse_idx, hold_cnt, nack_cnt, res_cnt, nack_idx, res_idx;
    bit  exp_tmo, exp_nack, exp_res, stretching, contiguous;
    string req;
    // clear flag first (R9)
    @(negedge clk);
    stretch_en = se; tmo_en = te; tmo_limit = TMO_W'(lim); tmo_clr = 1'b1;
    @(posedge clk); @(negedge clk);
    tmo_clr = 1'b0;
    check(tmo_flag == 1'b0, "R9", "flag after clear", int'(tmo_flag), 0);

    // expected values from the requirements
    stretching = se && trig;
    lc = te ? ((lim < 1) ? 1 : lim) : 1000;
    exp_r = 0; exp_tmo = 0; exp_pulse_idx = -1;
    if (stretching) begin
      exp_r = (d <= lc) ? d : lc;
      exp_tmo = (d > lc);
      if (exp_tmo) exp_pulse_idx = exp_r;
    end else if (trig) begin
      exp_pulse_idx = 0;
    end
    exp_nack = (exp_pulse_idx >= 0) && (!rd || addr);
    exp_res  = (exp_pulse_idx >= 0) && rd && !addr;

    // drive the strobe; the FIFO signal of the other direction is held at 1 (R2, R3)
    rw_read = rd; addr_phase = addr;
    txf_empty = rd ? trig : 1'b1;
    rxf_full  = rd ? 1'b1 : trig;
    ack_edge = 1'b1;
    @(posedge clk); @(negedge clk);
    ack_edge = 1'b0;

    hold_cnt = 0; nack_cnt = 0; res_cnt = 0; nack_idx = -1; res_idx = -1;
    contiguous = 1'b1;
    for (int k = 0; k <= NSAMP; k++) begin
      if (scl_hold) begin
        hold_cnt++;
        if (k != hold_cnt - 1) contiguous = 1'b0;
      end
      if (force_nack) begin nack_cnt++; if (nack_idx < 0) nack_idx = k; end
      if (resend_last) begin res_cnt++; if (res_idx < 0) res_idx = k; end
      if (k == NSAMP) break;
      if (k + 1 >= d) begin
        if (rd) txf_empty = 1'b0; else rxf_full = 1'b0;
      end
      if (k == 0 && stretching) ack_edge = 1'b1;  // R12: strobe during the hold
      @(posedge clk); @(negedge clk);
      ack_edge = 1'b0;
    end

    if (!trig)                 req = "R4";
    else if (!se)              req = "R11";
    else if (!te)              req = "R10";
    else if (exp_tmo)          req = "R6";
    else                       req = "R5";
    check(contiguous && hold_cnt == exp_r, req, "hold cycles", hold_cnt, exp_r);
    if (stretching) check(contiguous, "R12", "single hold run", int'(contiguous), 1);
    if (stretching && exp_r > 0)
      check(hold_cnt >= 1, rd ? "R2" : "R3", "hold raised", hold_cnt, 1);
    req = rd ? "R8" : "R7";
    check(nack_cnt == (exp_nack ? 1 : 0) && (!exp_nack || nack_idx == exp_pulse_idx),
          req, "nack pulse index", nack_idx, exp_nack ? exp_pulse_idx : -1);
    check(res_cnt == (exp_res ? 1 : 0) && (!exp_res || res_idx == exp_pulse_idx),
          "R8", "resend pulse index", res_idx, exp_res ? exp_pulse_idx : -1);
    check(tmo_flag == exp_tmo, se ? "R9" : "R11", "timeout flag",
          int'(tmo_flag), int'(exp_tmo));
    txf_empty = 1'b0; rxf_full = 1'b0;
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    check(scl_hold == 0 && force_nack == 0 && resend_last == 0 && tmo_flag == 0,
          "R1", "outputs in reset",
          int'({scl_hold, force_nack, resend_last, tmo_flag}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(scl_hold == 0 && force_nack == 0 && resend_last == 0 && tmo_flag == 0,
          "R1", "outputs after reset",
          int'({scl_hold, force_nack, resend_last, tmo_flag}), 0);

    for (int lim = 0; lim <= 4; lim++)
      for (int te = 0; te <= 1; te++)
        for (int se = 0; se <= 1; se++)
          for (int rd = 0; rd <= 1; rd++)
            for (int ad = 0; ad <= 1; ad++)
              for (int tg = 0; tg <= 1; tg++)
                for (int d = 1; d <= 7; d++)
                  run_case(lim, te[0], se[0], rd[0], ad[0], tg[0], d);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule